// File: doc/BRIEF.md
# Loop-Closing Branch Folding Unit

This unit sits between instruction fetch and decode. It removes the cost of the taken backward branch that closes a tight loop. When the core resolves a taken branch with a small negative displacement, the unit opens a single capture entry. The entry holds the branch address and the target address computed from the encoding. During the next pass through the loop, the entry also collects two instructions straight from fetch: the one at the target and the one just after the branch.

Once both instructions are held, the entry is armed. Each later fetch of the branch address then hands decode the stored target instruction in its place, together with the address and successor address of that instruction. A steering strobe sends fetch on from the target. When the armed branch finally resolves not-taken, the unit issues the stored fall-through instruction, steers fetch past it, and drops the entry.

A taken branch elsewhere, a flush, or a not-taken resolution during filling all empty the entry. An eligible taken branch at another address replaces it. Outputs are combinational from the current fetch and resolution inputs and the registered entry. Entry changes become visible from the next clock.

Top module: `loop_fold_unit`

## Requirements
- R1: After reset and whenever the unit does not steer, it passes fetch straight through: issueValid equals fetchValid, issueInstr equals fetchInstr, issuePc equals fetchPc, nextPc equals fetchPc + 2, and steerFetch and issueFolded are 0.
- R2: A loop branch is encoded with bits [15:11] = 5'b11110 and a signed halfword displacement in bits [10:0]. Its target is pc + 2*displacement. The branch is eligible only when the displacement lies between -MAX_BACK and -1 (default MAX_BACK = 16). Zero, positive and longer displacements are never folded.
- R3: A taken resolution of an eligible branch opens the entry, but the first pass runs unchanged: a fetch of the branch address is passed through.
- R4: The entry arms only after fetch has delivered both the instruction at the target address and the instruction at branch address + 2 after the entry opened. With only one of them held, no folding occurs.
- R5: With the entry armed, a fetch of the branch address issues the stored target instruction in the same cycle. In that cycle issuePc is the target, nextPc is target + 2, and steerFetch and issueFolded are 1.
- R6: A taken resolution of the armed branch leaves the entry armed.
- R7: A not-taken resolution of the armed branch issues the stored fall-through instruction in the same cycle, ignoring the fetch input. In that cycle issuePc is branch + 2, nextPc is branch + 4, steerFetch is 1 and issueFolded is 0. The entry is empty from the next cycle.
- R8: A taken resolution of a different eligible branch replaces the entry, which must then fill again before folding resumes.
- R9: A taken resolution of a non-eligible instruction at another address, or flushIn, empties the entry. A flush in the same cycle as a not-taken resolution of the armed branch suppresses the fall-through issue.
- R10: A not-taken resolution of the captured branch while the entry is still filling empties the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchValid | input | 1 | Fetch slot holds an instruction |
| fetchPc | input | AW | Address of fetched instruction |
| fetchInstr | input | 16 | Fetched instruction |
| resolveValid | input | 1 | A branch resolves this cycle |
| resolveTaken | input | 1 | Resolved branch was taken |
| resolvePc | input | AW | Address of resolved branch |
| resolveInstr | input | 16 | Encoding of resolved branch |
| flushIn | input | 1 | Pipeline flush or exception redirect |
| issueValid | output | 1 | Instruction offered to decode |
| issueInstr | output | 16 | Instruction offered to decode |
| issuePc | output | AW | Address of offered instruction |
| nextPc | output | AW | Address following the offered instruction |
| steerFetch | output | 1 | Fetch must restart at nextPc |
| issueFolded | output | 1 | Offered instruction replaces a folded branch |

## Verification
Every issue output (instruction, addresses, steer and fold flags) is due in the same cycle as the fetch or resolution that causes it. Any change to the capture entry first shows in the cycle after the clock edge that follows the causing input. The bench changes inputs on the falling edge and samples outputs 1 ns later, well before the next rising edge. It therefore reads each same-cycle result in its own cycle, and reads each entry change in the first cycle after the edge that records it. Scenarios that depend on entry state always put at least one clock edge between the filling stimulus and the fetch being checked.

// File: rtl/loop_fold_pkg.sv
package loop_fold_pkg;
  localparam int INSTR_W = 16;
  localparam int DISP_W  = 11;
  localparam logic [4:0] LOOP_OP = 5'b11110;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FILL,
    ST_ARMED
  } foldState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic learn;
    logic capTgt;
    logic capFall;
    logic useTgt;
    logic useFall;
  } foldCtl_t;

  // compare results from datapath to control
  typedef struct packed {
    logic fetchAtBr;
    logic fetchAtTgt;
    logic fetchAtFall;
    logic resolveAtBr;
    logic resolveEligible;
  } foldHit_t;
endpackage

// File: rtl/loop_fold_ctrl.sv
module loop_fold_ctrl
  import loop_fold_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     fetchValid,
  input  logic     resolveValid,
  input  logic     resolveTaken,
  input  logic     flushIn,
  input  foldHit_t hit,
  output foldCtl_t ctl
);
  foldState_t state, stateN;
  logic gotTgt, gotFall, gotTgtN, gotFallN;
  logic live, ownResolve, takenElse;

  always_comb begin
    live       = (state != ST_IDLE);
    ownResolve = live && hit.resolveAtBr;
    takenElse  = resolveValid && resolveTaken && !ownResolve;

    ctl = '0;
    ctl.useFall = (state == ST_ARMED) && resolveValid && !resolveTaken &&
                  hit.resolveAtBr && !flushIn;
    ctl.useTgt  = (state == ST_ARMED) && fetchValid && hit.fetchAtBr &&
                  !ctl.useFall && !flushIn;
    ctl.learn   = !flushIn && takenElse && hit.resolveEligible;
    ctl.capTgt  = (state == ST_FILL) && fetchValid && hit.fetchAtTgt &&
                  !ctl.learn && !flushIn;
    ctl.capFall = (state == ST_FILL) && fetchValid && hit.fetchAtFall &&
                  !ctl.learn && !flushIn;

    stateN   = state;
    gotTgtN  = gotTgt  || ctl.capTgt;
    gotFallN = gotFall || ctl.capFall;
    if (flushIn) begin
      stateN   = ST_IDLE;
      gotTgtN  = 1'b0;
      gotFallN = 1'b0;
    end else if (takenElse) begin
      stateN   = hit.resolveEligible ? ST_FILL : ST_IDLE;
      gotTgtN  = 1'b0;
      gotFallN = 1'b0;
    end else if (resolveValid && !resolveTaken && ownResolve) begin
      stateN   = ST_IDLE;
      gotTgtN  = 1'b0;
      gotFallN = 1'b0;
    end else if (state == ST_FILL && gotTgtN && gotFallN) begin
      stateN = ST_ARMED;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      gotTgt  <= 1'b0;
      gotFall <= 1'b0;
    end else begin
      state   <= stateN;
      gotTgt  <= gotTgtN;
      gotFall <= gotFallN;
    end
  end
endmodule

// File: rtl/loop_fold_dp.sv
module loop_fold_dp
  import loop_fold_pkg::*;
#(
  parameter int AW       = 32,
  parameter int MAX_BACK = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               fetchValid,
  input  logic [AW-1:0]      fetchPc,
  input  logic [INSTR_W-1:0] fetchInstr,
  input  logic [AW-1:0]      resolvePc,
  input  logic [INSTR_W-1:0] resolveInstr,
  input  foldCtl_t           ctl,
  output foldHit_t           hit,
  output logic               issueValid,
  output logic [INSTR_W-1:0] issueInstr,
  output logic [AW-1:0]      issuePc,
  output logic [AW-1:0]      nextPc,
  output logic               steerFetch,
  output logic               issueFolded
);
  localparam int MAG_W = DISP_W + 1;
  localparam logic [AW-1:0] STEP  = AW'(2);
  localparam logic [AW-1:0] STEP2 = AW'(4);

  logic [AW-1:0]      brPc, tgtPc;
  logic [INSTR_W-1:0] tgtInstr, fallInstr;
  logic [MAG_W-1:0]   backMag;
  logic [AW-1:0]      learnTgt;
  logic               isLoopOp;

  always_comb begin
    isLoopOp = (resolveInstr[INSTR_W-1:DISP_W] == LOOP_OP);
    backMag  = MAG_W'(-$signed({resolveInstr[DISP_W-1], resolveInstr[DISP_W-1:0]}));
    learnTgt = resolvePc +
               {{(AW-DISP_W-1){resolveInstr[DISP_W-1]}}, resolveInstr[DISP_W-1:0], 1'b0};

    hit.resolveEligible = isLoopOp && resolveInstr[DISP_W-1] &&
                          (backMag <= MAG_W'(MAX_BACK));
    hit.fetchAtBr   = (fetchPc == brPc);
    hit.fetchAtTgt  = (fetchPc == tgtPc);
    hit.fetchAtFall = (fetchPc == brPc + STEP);
    hit.resolveAtBr = (resolvePc == brPc);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      brPc      <= '0;
      tgtPc     <= '0;
      tgtInstr  <= '0;
      fallInstr <= '0;
    end else begin
      if (ctl.learn) begin
        brPc  <= resolvePc;
        tgtPc <= learnTgt;
      end
      if (ctl.capTgt)  tgtInstr  <= fetchInstr;
      if (ctl.capFall) fallInstr <= fetchInstr;
    end
  end

  always_comb begin
    issueValid  = fetchValid || ctl.useFall;
    steerFetch  = ctl.useFall || ctl.useTgt;
    issueFolded = ctl.useTgt;
    if (ctl.useFall) begin
      issueInstr = fallInstr;
      issuePc    = brPc + STEP;
      nextPc     = brPc + STEP2;
    end else if (ctl.useTgt) begin
      issueInstr = tgtInstr;
      issuePc    = tgtPc;
      nextPc     = tgtPc + STEP;
    end else begin
      issueInstr = fetchInstr;
      issuePc    = fetchPc;
      nextPc     = fetchPc + STEP;
    end
  end
endmodule

// File: rtl/loop_fold_unit.sv
module loop_fold_unit
  import loop_fold_pkg::*;
#(
  parameter int AW       = 32,
  parameter int MAX_BACK = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               fetchValid,
  input  logic [AW-1:0]      fetchPc,
  input  logic [INSTR_W-1:0] fetchInstr,
  input  logic               resolveValid,
  input  logic               resolveTaken,
  input  logic [AW-1:0]      resolvePc,
  input  logic [INSTR_W-1:0] resolveInstr,
  input  logic               flushIn,
  output logic               issueValid,
  output logic [INSTR_W-1:0] issueInstr,
  output logic [AW-1:0]      issuePc,
  output logic [AW-1:0]      nextPc,
  output logic               steerFetch,
  output logic               issueFolded
);
  foldCtl_t ctl;
  foldHit_t hit;

  loop_fold_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .fetchValid   (fetchValid),
    .resolveValid (resolveValid),
    .resolveTaken (resolveTaken),
    .flushIn      (flushIn),
    .hit          (hit),
    .ctl          (ctl)
  );

  loop_fold_dp #(.AW(AW), .MAX_BACK(MAX_BACK)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .fetchValid   (fetchValid),
    .fetchPc      (fetchPc),
    .fetchInstr   (fetchInstr),
    .resolvePc    (resolvePc),
    .resolveInstr (resolveInstr),
    .ctl          (ctl),
    .hit          (hit),
    .issueValid   (issueValid),
    .issueInstr   (issueInstr),
    .issuePc      (issuePc),
    .nextPc       (nextPc),
    .steerFetch   (steerFetch),
    .issueFolded  (issueFolded)
  );
endmodule

// File: rtl/loop_fold_unit_chk.sv
module loop_fold_unit_chk #(
  parameter int AW       = 32,
  parameter int MAX_BACK = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          fetchValid,
  input logic [AW-1:0] fetchPc,
  input logic          resolveValid,
  input logic          resolveTaken,
  input logic [AW-1:0] resolvePc,
  input logic          flushIn,
  input logic          issueValid,
  input logic [AW-1:0] issuePc,
  input logic [AW-1:0] nextPc,
  input logic          steerFetch,
  input logic          issueFolded
);
  // R9
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushIn |=> !issueFolded);

  // R5
  fold_backward_chk: assert property (@(posedge clk) disable iff (!rstN)
    issueFolded |-> (fetchValid && steerFetch && (issuePc < fetchPc) &&
                     ((fetchPc - issuePc) <= AW'(2 * MAX_BACK)) &&
                     (nextPc == issuePc + AW'(2))));

  // R7
  exit_path_chk: assert property (@(posedge clk) disable iff (!rstN)
    (steerFetch && !issueFolded) |-> (resolveValid && !resolveTaken && issueValid &&
                                      (issuePc == resolvePc + AW'(2)) &&
                                      (nextPc == resolvePc + AW'(4))));

  // R7
  exit_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    (steerFetch && !issueFolded) |=> !issueFolded);

  // R1
  passthrough_chk: assert property (@(posedge clk) disable iff (!rstN)
    !steerFetch |-> ((issueValid == fetchValid) && !issueFolded &&
                     (!fetchValid || ((issuePc == fetchPc) && (nextPc == fetchPc + AW'(2))))));
endmodule

bind loop_fold_unit loop_fold_unit_chk #(.AW(AW), .MAX_BACK(MAX_BACK)) u_chk (.*);

// File: tb/loop_fold_unit_tb.sv
module loop_fold_unit_tb;
  localparam int AW = 32;
  localparam int MAX_BACK = 16;

  logic clk = 1'b0;
  logic rstN;
  logic fetchValid, resolveValid, resolveTaken, flushIn;
  logic [AW-1:0] fetchPc, resolvePc;
  logic [15:0] fetchInstr, resolveInstr;
  logic issueValid, steerFetch, issueFolded;
  logic [15:0] issueInstr;
  logic [AW-1:0] issuePc, nextPc;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  loop_fold_unit #(.AW(AW), .MAX_BACK(MAX_BACK)) u_dut (.*);

  function automatic logic [15:0] mkBr(int disp);
    return {5'b11110, 11'(disp)};
  endfunction

  task automatic setIn(logic fv, logic [AW-1:0] fpc, logic [15:0] fi,
                       logic rv, logic rt, logic [AW-1:0] rpc, logic [15:0] ri, logic fl);
    fetchValid = fv; fetchPc = fpc; fetchInstr = fi;
    resolveValid = rv; resolveTaken = rt; resolvePc = rpc; resolveInstr = ri;
    flushIn = fl;
  endtask

  task automatic tick();
    @(negedge clk);
    setIn(0, '0, '0, 0, 0, '0, '0, 0);
  endtask

  task automatic chk(string tag, logic ev, logic [15:0] ei, logic [AW-1:0] ep,
                     logic [AW-1:0] en, logic es, logic ef);
    checks++;
    if (issueValid !== ev || steerFetch !== es || issueFolded !== ef ||
        (ev && (issueInstr !== ei || issuePc !== ep || nextPc !== en))) begin
      errors++;
      $display("FAIL %s: got v=%0b i=%h pc=%h np=%h s=%0b f=%0b exp v=%0b i=%h pc=%h np=%h s=%0b f=%0b",
               tag, issueValid, issueInstr, issuePc, nextPc, steerFetch, issueFolded,
               ev, ei, ep, en, es, ef);
    end
  endtask

  task automatic passCheck(string tag, logic [AW-1:0] pc, logic [15:0] ins);
    setIn(1, pc, ins, 0, 0, '0, '0, 0);
    #1 chk(tag, 1, ins, pc, pc + 2, 0, 0);
    tick();
  endtask

  task automatic learn(logic [AW-1:0] bpc, logic [15:0] bi);
    setIn(0, '0, '0, 1, 1, bpc, bi, 0);
    tick();
  endtask

  task automatic feed(logic [AW-1:0] pc, logic [15:0] ins);
    setIn(1, pc, ins, 0, 0, '0, '0, 0);
    tick();
  endtask

  task automatic flushOnce();
    setIn(0, '0, '0, 0, 0, '0, '0, 1);
    tick();
  endtask

  task automatic armA();
    learn(32'h100, mkBr(-4));
    feed(32'hF8, 16'h1111);
    feed(32'h102, 16'h2222);
  endtask

  task automatic testReset();
    setIn(0, '0, '0, 0, 0, '0, '0, 0);
    #1 chk("R1 idle after reset", 0, '0, '0, '0, 0, 0);
    tick();
    passCheck("R1 branch passed through after reset", 32'h100, mkBr(-4));
  endtask

  task automatic testEligible();
    flushOnce();
    learn(32'h200, mkBr(-16));
    feed(32'h1E0, 16'hAAAA);
    feed(32'h202, 16'hBBBB);
    setIn(1, 32'h200, mkBr(-16), 0, 0, '0, '0, 0);
    #1 chk("R2 limit displacement folds", 1, 16'hAAAA, 32'h1E0, 32'h1E2, 1, 1);
    tick();
    flushOnce();
    learn(32'h300, mkBr(-17));
    feed(32'h2DE, 16'hCCCC);
    feed(32'h302, 16'hDDDD);
    passCheck("R2 displacement beyond limit not folded", 32'h300, mkBr(-17));
    learn(32'h300, mkBr(4));
    feed(32'h308, 16'hCCCC);
    feed(32'h302, 16'hDDDD);
    passCheck("R2 forward displacement not folded", 32'h300, mkBr(4));
    learn(32'h300, mkBr(0));
    feed(32'h300, 16'hCCCC);
    feed(32'h302, 16'hDDDD);
    passCheck("R2 zero displacement not folded", 32'h300, mkBr(0));
  endtask

  task automatic testFirstPass();
    flushOnce();
    learn(32'h100, mkBr(-4));
    passCheck("R3 first pass unchanged", 32'h100, mkBr(-4));
    feed(32'hF8, 16'h1111);
    passCheck("R4 target only, no fold", 32'h100, mkBr(-4));
    feed(32'h102, 16'h2222);
    setIn(1, 32'h100, mkBr(-4), 0, 0, '0, '0, 0);
    #1 chk("R4 armed after both captured", 1, 16'h1111, 32'hF8, 32'hFA, 1, 1);
    tick();
  endtask

  task automatic testFoldKeep();
    flushOnce();
    armA();
    setIn(1, 32'h100, mkBr(-4), 0, 0, '0, '0, 0);
    #1 chk("R5 folded issue", 1, 16'h1111, 32'hF8, 32'hFA, 1, 1);
    tick();
    setIn(1, 32'hFA, 16'h7777, 1, 1, 32'h100, mkBr(-4), 0);
    #1 chk("R6 taken resolve cycle passes fetch", 1, 16'h7777, 32'hFA, 32'hFC, 0, 0);
    tick();
    setIn(1, 32'h100, mkBr(-4), 0, 0, '0, '0, 0);
    #1 chk("R6 still folding after taken", 1, 16'h1111, 32'hF8, 32'hFA, 1, 1);
    tick();
  endtask

  task automatic testExit();
    flushOnce();
    armA();
    setIn(1, 32'h100, mkBr(-4), 1, 0, 32'h100, mkBr(-4), 0);
    #1 chk("R7 fall-through issued on exit", 1, 16'h2222, 32'h102, 32'h104, 1, 0);
    tick();
    passCheck("R7 entry empty after exit", 32'h100, mkBr(-4));
  endtask

  task automatic testOverwrite();
    flushOnce();
    armA();
    learn(32'h400, mkBr(-2));
    passCheck("R8 old loop no longer folds", 32'h100, mkBr(-4));
    passCheck("R8 new loop not folded before refill", 32'h400, mkBr(-2));
    feed(32'h3FC, 16'h3333);
    feed(32'h402, 16'h4444);
    setIn(1, 32'h400, mkBr(-2), 0, 0, '0, '0, 0);
    #1 chk("R8 new loop folds", 1, 16'h3333, 32'h3FC, 32'h3FE, 1, 1);
    tick();
  endtask

  task automatic testClear();
    flushOnce();
    armA();
    setIn(0, '0, '0, 1, 1, 32'h500, 16'h0000, 0);
    #1 chk("R9 other taken branch cycle", 0, '0, '0, '0, 0, 0);
    tick();
    passCheck("R9 cleared by other taken branch", 32'h100, mkBr(-4));
    armA();
    setIn(1, 32'h100, mkBr(-4), 0, 0, '0, '0, 1);
    #1 chk("R9 flush suppresses fold", 1, mkBr(-4), 32'h100, 32'h102, 0, 0);
    tick();
    passCheck("R9 cleared by flush", 32'h100, mkBr(-4));
    armA();
    setIn(1, 32'h500, 16'h5555, 1, 0, 32'h100, mkBr(-4), 1);
    #1 chk("R9 flush suppresses exit", 1, 16'h5555, 32'h500, 32'h502, 0, 0);
    tick();
  endtask

  task automatic testFillAbort();
    flushOnce();
    learn(32'h100, mkBr(-4));
    feed(32'hF8, 16'h1111);
    setIn(0, '0, '0, 1, 0, 32'h100, mkBr(-4), 0);
    #1 chk("R10 not-taken during fill issues nothing", 0, '0, '0, '0, 0, 0);
    tick();
    feed(32'h102, 16'h2222);
    passCheck("R10 entry emptied during fill", 32'h100, mkBr(-4));
  endtask

  initial begin
    #800000;
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish, got timeout exp completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    setIn(0, '0, '0, 0, 0, '0, '0, 0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testEligible();
    testFirstPass();
    testFoldKeep();
    testExit();
    testOverwrite();
    testClear();
    testFillAbort();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule